// File: doc/BRIEF.md
# Multiplexed Seven-Digit Display Scanner with Leading-Zero Blanking

This block drives a seven-digit numeric display through one shared segment bus. A repeating sequence of eight time slots is stepped by a scan tick, nominally around 2 kHz. The tick comes either from an internal source or from an external one, chosen by a select input. Slot 0 is a quiet slot. Slots 1 to 7 each light one digit position, starting at the most significant (10^6) and ending at the least significant (10^0). In each lit slot the block enables that position's common line, decodes the matching BCD digit to segment drives, and lights the decimal point in the position picked by a range select.

Zeros ahead of the first significant digit are blanked by a one-bit suppress state. This state is set during slot 0. At the end of each slot it takes the ripple-blank result of that slot, so blanking stops at the first nonzero digit. Blanking is always off from slot 5 onward, which keeps zeros after the decimal point visible. An overflow flag turns blanking off for the whole scan, because the true count is larger than the display can show.

Top module: `disp_scan_top`

## Requirements
- R1: While rst_n is low at a clock edge, the slot index returns to 0, and after that edge dig_en_o, seg_o and dp_o are all zero.
- R2: The slot index advances by one at each clock edge where the selected tick is high, and wraps from 7 to 0. The selected tick is tick_ext when use_ext is 1 and tick_int when use_ext is 0. A pulse on the tick that is not selected leaves the slot index unchanged.
- R3: In slot 0, dig_en_o is zero, seg_o is zero and dp_o is low.
- R4: In slot s (1 to 7), only dig_en_o bit s-1 is high. The digit shown is digits_i[4*(7-s)+3 : 4*(7-s)], so slot 1 shows the 10^6 digit and slot 7 shows the 10^0 digit.
- R5: seg_o is active high, with bit 0 = a through bit 6 = g. The codes 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R6: BCD codes 10 to 15 give seg_o = 0. For blanking purposes they count as nonzero, so they end leading-zero blanking.
- R7: In slots 1 to 4, a zero digit is dark while no nonzero digit has appeared earlier in the same scan. Once a nonzero digit has appeared, later zeros show as 3F.
- R8: In slots 5, 6 and 7, a zero digit always shows as 3F.
- R9: While ovf_i is high, zero digits in slots 1 to 7 show as 3F.
- R10: dp_o is high only in slot 3 when dp_pos_i is 0, and only in slot 4 when dp_pos_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_int | input | 1 | Internal scan tick, one-cycle pulse |
| tick_ext | input | 1 | External scan tick, one-cycle pulse, synchronous to clk |
| use_ext | input | 1 | 1 selects the external tick |
| digits_i | input | 28 | Seven BCD digits, most significant in bits 27:24 |
| dp_pos_i | input | 1 | Decimal point position: 0 = slot 3, 1 = slot 4 |
| ovf_i | input | 1 | Overflow flag; disables zero blanking |
| dig_en_o | output | 7 | One-hot digit enables; bit 0 is the leftmost position |
| seg_o | output | 7 | Segment drives a..g, active high |
| dp_o | output | 1 | Decimal point drive |
| slot_o | output | 3 | Current time slot index |

## Verification
Full scans are run with several digit patterns, each aimed at one part of the blanking logic:
- Leading zeros followed by a value, to show that blanking stops at the first nonzero digit.
- An all-zero word, to show that slot 5 forces zeros visible.
- A value with zeros between nonzero digits, to show that blanking does not resume once ended.
- All zeros with overflow raised, to show that the override wins.

One scan uses codes 10 to 15, to separate "dark because invalid" from "dark because blanked". Both decimal-point settings and both tick sources are used. A pulse on the unselected tick is shown to leave the slot unchanged.

// File: rtl/disp_scan_pkg.sv
// Package: shared widths and the BCD-to-segment pattern function for the
// display scanner. Assumes segments are active high with bit 0 = a.
package disp_scan_pkg;

    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    // Map a BCD code to its segment pattern; codes above 9 give all-dark.
    function automatic logic [SEG_W-1:0] seg_pattern(input logic [BCD_W-1:0] code);
        logic [SEG_W-1:0] pat;
        case (code)
            4'd0:    pat = 7'h3F;
            4'd1:    pat = 7'h06;
            4'd2:    pat = 7'h5B;
            4'd3:    pat = 7'h4F;
            4'd4:    pat = 7'h66;
            4'd5:    pat = 7'h6D;
            4'd6:    pat = 7'h7D;
            4'd7:    pat = 7'h07;
            4'd8:    pat = 7'h7F;
            4'd9:    pat = 7'h6F;
            default: pat = '0;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/scan_tick_mux.sv
// Module: scan_tick_mux
// Picks the scan tick source. Both ticks are assumed to be single-cycle
// pulses that are already synchronous to clk.
module scan_tick_mux (
    input  logic tick_int,
    input  logic tick_ext,
    input  logic use_ext,
    output logic tick
);

    // Route the selected source to the sequencer.
    always_comb tick = use_ext ? tick_ext : tick_int;

endmodule

// File: rtl/slot_seq.sv
// Module: slot_seq
// Modulo-NUM_SLOTS slot counter, stepped by tick, plus a one-hot decode of
// the current slot. Assumes NUM_SLOTS >= 2.
module slot_seq #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    output logic [SLOT_W-1:0]    slot,
    output logic [NUM_SLOTS-1:0] slot_hot
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;

    // Advance the slot on each tick, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (tick)
            slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end

    assign slot = slot_q;

    // One-hot decode, one comparator per slot.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hot
        assign slot_hot[s] = (slot_q == SLOT_W'(s));
    end

endmodule

// File: rtl/zero_blank_ctrl.sv
// Module: zero_blank_ctrl
// Holds the one-bit leading-zero suppress state. The state is forced on
// during slot 0 and takes the inverse of the decoder's ripple-blank output
// at each tick. The effective blanking enable is off in slot 0, from
// BLANK_STOP onward, and whenever overflow is flagged.
module zero_blank_ctrl #(
    parameter int SLOT_W     = 3,
    parameter int BLANK_STOP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SLOT_W-1:0] slot,
    input  logic              slot_zero,
    input  logic              ovf,
    input  logic              rbo,
    output logic              blank_en
);

    logic sup_q;

    // Suppress state: set in slot 0, then follows ripple-blank at slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sup_q <= 1'b1;
        else if (slot_zero)
            sup_q <= 1'b1;
        else if (tick)
            sup_q <= ~rbo;
    end

    // Effective blanking, with the forced-off windows applied.
    always_comb
        blank_en = sup_q & ~ovf & ~slot_zero & (slot < SLOT_W'(BLANK_STOP));

endmodule

// File: rtl/bcd_seg_dec.sv
// Module: bcd_seg_dec
// Decodes one BCD digit to segments, with a blanking input and a
// ripple-blank output. rbo goes low only when a zero is being blanked.
module bcd_seg_dec
    import disp_scan_pkg::*;
(
    input  logic             active,
    input  logic [BCD_W-1:0] code,
    input  logic             blank_in,
    output logic [SEG_W-1:0] seg,
    output logic             rbo
);

    logic is_zero;

    // Detect a zero digit that blanking should hide.
    always_comb is_zero = (code == '0);

    // Segment drive: dark when idle or when a blanked zero is shown.
    always_comb begin
        if (!active || (blank_in && is_zero))
            seg = '0;
        else
            seg = seg_pattern(code);
    end

    // Ripple-blank out: low only while a zero is being suppressed.
    always_comb rbo = ~(blank_in & is_zero);

endmodule

// File: rtl/disp_scan_top.sv
// Module: disp_scan_top
// Seven-digit multiplexed display scanner. Slot 0 is idle; slots
// 1..NUM_DIGITS show digits from most to least significant. Outputs are
// combinational from the slot and suppress registers. Assumes the ticks
// are one-cycle pulses synchronous to clk.
module disp_scan_top
    import disp_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 7,
    parameter int DP_SLOT_A  = 3,
    parameter int DP_SLOT_B  = 4,
    parameter int BLANK_STOP = 5,
    localparam int NUM_SLOTS = NUM_DIGITS + 1,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int DIG_BITS  = NUM_DIGITS * BCD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_int,
    input  logic                  tick_ext,
    input  logic                  use_ext,
    input  logic [DIG_BITS-1:0]   digits_i,
    input  logic                  dp_pos_i,
    input  logic                  ovf_i,
    output logic [NUM_DIGITS-1:0] dig_en_o,
    output logic [SEG_W-1:0]      seg_o,
    output logic                  dp_o,
    output logic [SLOT_W-1:0]     slot_o
);

    logic                 tick;
    logic [SLOT_W-1:0]    slot;
    logic [NUM_SLOTS-1:0] slot_hot;
    logic                 blank_en;
    logic                 rbo;
    logic [BCD_W-1:0]     cur_digit;
    logic [BCD_W-1:0]     pick [NUM_SLOTS];

    scan_tick_mux u_tick (
        .tick_int (tick_int),
        .tick_ext (tick_ext),
        .use_ext  (use_ext),
        .tick     (tick)
    );

    slot_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .slot     (slot),
        .slot_hot (slot_hot)
    );

    // Gate each digit by its slot line; the leftmost digit uses slot 1.
    assign pick[0] = '0;
    for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_pick
        assign pick[s] = slot_hot[s] ? digits_i[BCD_W*(NUM_DIGITS-s) +: BCD_W] : '0;
        assign dig_en_o[s-1] = slot_hot[s];
    end

    // OR the gated digits onto the shared digit bus.
    always_comb begin
        cur_digit = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            cur_digit = cur_digit | pick[s];
    end

    zero_blank_ctrl #(.SLOT_W(SLOT_W), .BLANK_STOP(BLANK_STOP)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .slot      (slot),
        .slot_zero (slot_hot[0]),
        .ovf       (ovf_i),
        .rbo       (rbo),
        .blank_en  (blank_en)
    );

    bcd_seg_dec u_dec (
        .active   (~slot_hot[0]),
        .code     (cur_digit),
        .blank_in (blank_en),
        .seg      (seg_o),
        .rbo      (rbo)
    );

    // Decimal point: one of two slots, picked by the range select.
    always_comb
        dp_o = dp_pos_i ? slot_hot[DP_SLOT_B] : slot_hot[DP_SLOT_A];

    assign slot_o = slot;

endmodule

// File: rtl/disp_scan_chk.sv
// Module: disp_scan_chk
// Assertion checker for disp_scan_top, attached by bind. It relates the
// port values over time; it holds no copy of the design's state.
module disp_scan_chk #(
    parameter int NUM_DIGITS = 7,
    localparam int NUM_SLOTS = NUM_DIGITS + 1,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_int,
    input logic                    tick_ext,
    input logic                    use_ext,
    input logic [NUM_DIGITS*4-1:0] digits_i,
    input logic                    dp_pos_i,
    input logic                    ovf_i,
    input logic [NUM_DIGITS-1:0]   dig_en_o,
    input logic [6:0]              seg_o,
    input logic                    dp_o,
    input logic [SLOT_W-1:0]       slot_o
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic       sel_tick;
    logic [3:0] shown;
    logic [SLOT_W-1:0] nxt;

    always_comb sel_tick = use_ext ? tick_ext : tick_int;
    always_comb shown = 4'(digits_i >> (4 * (NUM_DIGITS - int'(slot_o))));
    always_comb nxt = (slot_o == LAST) ? '0 : slot_o + 1'b1;

    logic [SLOT_W-1:0] nxt_q;
    always_ff @(posedge clk) nxt_q <= nxt;

    assert_slot_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_tick |=> slot_o == nxt_q);

    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> $stable(slot_o));

    assert_idle_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o == '0 |-> (dig_en_o == '0 && seg_o == '0 && !dp_o));

    assert_one_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o != '0 |-> ($countones(dig_en_o) == 1 && dig_en_o[slot_o - 1'b1]));

    assert_bad_code_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o != '0 && shown > 4'd9) |-> seg_o == '0);

    assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o >= SLOT_W'(5) && shown == 4'd0) |-> seg_o == 7'h3F);

    assert_ovf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && slot_o != '0 && shown == 4'd0) |-> seg_o == 7'h3F);

    assert_dp_place_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dp_o |-> ((slot_o == SLOT_W'(3) && !dp_pos_i) || (slot_o == SLOT_W'(4) && dp_pos_i)));

endmodule

bind disp_scan_top disp_scan_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_int (tick_int),
    .tick_ext (tick_ext),
    .use_ext  (use_ext),
    .digits_i (digits_i),
    .dp_pos_i (dp_pos_i),
    .ovf_i    (ovf_i),
    .dig_en_o (dig_en_o),
    .seg_o    (seg_o),
    .dp_o     (dp_o),
    .slot_o   (slot_o)
);

// File: tb/disp_scan_top_tb_top.sv
// Scoreboard bench: the driver pushes the expected outputs of each slot
// into a queue, and the monitor pops them and compares at the falling edge.
module disp_scan_top_tb_top;

    typedef struct {
        logic [2:0] slot;
        logic [6:0] en;
        logic [6:0] seg;
        logic       dp;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_int = 1'b0;
    logic        tick_ext = 1'b0;
    logic        use_ext = 1'b0;
    logic [27:0] digits_i = '0;
    logic        dp_pos_i = 1'b0;
    logic        ovf_i = 1'b0;
    logic [6:0]  dig_en_o;
    logic [6:0]  seg_o;
    logic        dp_o;
    logic [2:0]  slot_o;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    exp_t item;

    always #4 clk = ~clk;

    disp_scan_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_int (tick_int),
        .tick_ext (tick_ext),
        .use_ext  (use_ext),
        .digits_i (digits_i),
        .dp_pos_i (dp_pos_i),
        .ovf_i    (ovf_i),
        .dig_en_o (dig_en_o),
        .seg_o    (seg_o),
        .dp_o     (dp_o),
        .slot_o   (slot_o)
    );

    // Segment patterns from R5; codes above 9 are dark per R6.
    function automatic logic [6:0] ref_seg(input logic [3:0] d);
        case (d)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    // Monitor: compare one expected item per falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item = sb_q.pop_front();
            checks++;
            if (slot_o !== item.slot || dig_en_o !== item.en ||
                seg_o !== item.seg || dp_o !== item.dp) begin
                errors++;
                $display("FAIL %s: got slot=%0d en=%h seg=%h dp=%b, expected slot=%0d en=%h seg=%h dp=%b",
                         item.tag, slot_o, dig_en_o, seg_o, dp_o,
                         item.slot, item.en, item.seg, item.dp);
            end
        end
    end

    // Push the expected idle-slot item (R1/R3 shape).
    task automatic push_idle(input string tag);
        exp_t e;
        e.slot = 3'd0; e.en = '0; e.seg = '0; e.dp = 1'b0; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Drive one full scan and push the expected result of every slot.
    task automatic scan_frame(input logic [27:0] digs, input logic dps,
                              input logic ovf, input logic ext, input string tag);
        logic sup;
        @(posedge clk); #1;
        digits_i = digs; dp_pos_i = dps; ovf_i = ovf; use_ext = ext;
        sup = 1'b1;
        for (int s = 0; s < 8; s++) begin
            exp_t e;
            logic [3:0] d;
            logic eff;
            if (s > 0) begin @(posedge clk); #1; end
            tick_int = 1'b0; tick_ext = 1'b0;
            d   = (s == 0) ? 4'd0 : digs[4*(7-s) +: 4];
            eff = sup && !ovf && s >= 1 && s <= 4;
            e.slot = 3'(s);
            e.en   = (s == 0) ? 7'd0 : 7'(1 << (s - 1));
            e.seg  = (s == 0) ? 7'd0 : ((eff && d == 4'd0) ? 7'd0 : ref_seg(d));
            e.dp   = dps ? (s == 4) : (s == 3);
            e.tag  = $sformatf("%s slot%0d (R4 R5 R6 R7 R8 R9 R10)", tag, s);
            sb_q.push_back(e);
            sup = (s == 0) ? 1'b1 : (eff && d == 4'd0);
            @(negedge clk); #1;
            if (ext) tick_ext = 1'b1; else tick_int = 1'b1;
        end
        @(posedge clk); #1;
        tick_int = 1'b0; tick_ext = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        push_idle("R1 reset state");
        @(posedge clk); #1;
        rst_n = 1'b1;
        push_idle("R3 idle slot after reset");
        @(negedge clk);

        // R7: leading zeros blank until the first nonzero digit.
        scan_frame(28'h0000123, 1'b0, 1'b0, 1'b0, "R7 leading zeros");
        // R8: all zeros, slots 5..7 still shown; R10 second dp position.
        scan_frame(28'h0000000, 1'b1, 1'b0, 1'b0, "R8 all zeros");
        // R7: inner zeros stay visible once blanking ended.
        scan_frame(28'h1020304, 1'b0, 1'b0, 1'b0, "R7 inner zeros");
        // R9: overflow shows every zero.
        scan_frame(28'h0000000, 1'b0, 1'b1, 1'b0, "R9 overflow");
        // R6 and R2: invalid codes dark and end blanking, external tick.
        scan_frame(28'h0A00B05, 1'b1, 1'b0, 1'b1, "R6 invalid codes ext");
        // R5: every other digit pattern, internal tick.
        scan_frame(28'h9876543, 1'b0, 1'b0, 1'b0, "R5 patterns");

        // R2: the unselected external tick must not move the slot.
        @(posedge clk); #1;
        use_ext = 1'b0; tick_ext = 1'b1;
        @(posedge clk); #1;
        tick_ext = 1'b0;
        push_idle("R2 unselected ext tick ignored");
        @(negedge clk);
        // R2: the unselected internal tick must not move the slot.
        @(posedge clk); #1;
        use_ext = 1'b1; tick_int = 1'b1;
        @(posedge clk); #1;
        tick_int = 1'b0;
        push_idle("R2 unselected int tick ignored");
        @(negedge clk);
        // R2: wrap, a full scan on the external tick again.
        scan_frame(28'h0003000, 1'b1, 1'b0, 1'b1, "R2 wrap ext");

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: got %0d pending items, expected 0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule